// File: doc/BRIEF.md
# Programmable Event Counter Unit

This block is a register-programmed performance monitor made of ten independent 32-bit counters. Counters 0 to 7 form a half-rate group. Counters 8 and 9 form a full-rate group. Each counter has its own control word, a 45-bit mask and match pair, and a value register that software can read and preload. On every cycle a counter may add to its value. It does so only when three things hold: it is enabled, its group's clock-enable is high, and its selected event passes the mask/match qualifier.

When a counter wraps past its top value, it sets a sticky bit in its group's overflow status register. A single interrupt line stays high while any status bit in either group is set.

Software uses the block through a plain 32-bit register port. Writes take effect at the clock edge, and reads are combinational from the address. Event inputs come in per group. Each group also has a small increment-value bus. A shared qualifier data bus feeds the mask/match comparison of every counter. There is no master enable: each counter starts and stops only through its own control word.

Top module: `evcnt_unit`

## Requirements
- R1: After reset every control word, mask, match, counter value and both status registers read 0, and `irq` is low.
- R2: Register map (byte addresses):
  - The half-group status register is at 0x8 and the full-group status register is at 0xC.
  - Counter n's registers start at 0x10 + 0x28*n. Within that span:
    - +0x0 is mask bits 31:0, and +0x4 is mask bits 44:32 in data bits 12:0.
    - +0x8 is match bits 31:0, and +0xC is match bits 44:32 in data bits 12:0.
    - +0x10 is the control word, which keeps data bits 8:0.
    - +0x20 is the value.
  - Every other address reads 0.
- R3: Control word fields:
  - Bit 0 enables the counter. Bit 1 inverts the qualifier result.
  - Bits 6:2 select the event. Bits 8:7 select the increment mode.
  - A counter whose enable bit is 0 never changes except by a value write.
- R4: Event select 0 is active on every cycle. A half-group counter advances only in cycles where `half_ce` is 1, while full-group counters may advance on every cycle. Selects at or above a group's event count (26 for the half group, 3 for the full group) never count.
- R5: A selected, active event counts when `(qual_data & mask) == (match & mask)`, with that comparison inverted when the invert bit is set.
- R6: Increment mode 0 adds 1, mode 1 adds 2, and mode 2 adds the group's increment bus (`half_inc` or `full_inc`) on each counting cycle. Mode 3 adds nothing.
- R7: A write to the value register loads it at the edge, and wins over a count in the same cycle. Counting wraps modulo 2^32.
- R8: When a counter carries out of bit 31, its group status bit is set at the same edge and stays set. Bit n of 0x8 belongs to counter n; bit n-8 of 0xC belongs to counter n.
- R9: A status write clears the bits written as 0 and leaves the bits written as 1 unchanged. A wrap in the same cycle as a clear leaves its bit set.
- R10: `irq` is 1 exactly when some bit of either status register is 1.
- R11: Counting on one counter never changes another counter's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_ce | input | 1 | Advance enable for the half-rate group |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| ev_half | input | 25 | Half-group events 1..25 (event 0 is internal) |
| ev_full | input | 2 | Full-group events 1..2 (event 0 is internal) |
| qual_data | input | 45 | Data compared against each counter's mask/match |
| half_inc | input | 4 | Increment value for mode 2, half group |
| full_inc | input | 4 | Increment value for mode 2, full group |
| irq | output | 1 | High while any overflow status bit is set |

## Verification
The following are checked on every cycle by the assertions:
- value loading and precedence over counting;
- holding while disabled, gated by `half_ce`, or in increment mode 3;
- single-step counting;
- stickiness of the overflow bits against everything except a status write;
- the raising of `irq` after a wrap.

Other behaviours only the bench's scenarios can show:
- the exact address decode;
- the mask/match qualification with and without inversion;
- the ignored event selects;
- the coincidence of a wrap with a status clear in the same cycle;
- the isolation between counters.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;

  localparam int CNT_W  = 32;
  localparam int QUAL_W = 45;
  localparam int INC_W  = 4;
  localparam int CTRL_W = 9;
  localparam int HI_W   = QUAL_W - 32;

  typedef enum logic [1:0] {
    INC_ONE  = 2'd0,
    INC_TWO  = 2'd1,
    INC_EXT  = 2'd2,
    INC_NONE = 2'd3
  } inc_mode_e;

  // Field order matters: mode[8:7], sel[6:2], inv[1], en[0]
  typedef struct packed {
    inc_mode_e   mode;
    logic [4:0]  sel;
    logic        inv;
    logic        en;
  } ctrl_t;

  function automatic logic qual_pass(input logic [QUAL_W-1:0] data,
                                     input logic [QUAL_W-1:0] mask,
                                     input logic [QUAL_W-1:0] match,
                                     input logic             inv);
    return ((data & mask) == (match & mask)) ^ inv;
  endfunction

  function automatic logic [CNT_W-1:0] step_amount(input inc_mode_e mode,
                                                   input logic [INC_W-1:0] ext);
    case (mode)
      INC_ONE: return CNT_W'(1);
      INC_TWO: return CNT_W'(2);
      INC_EXT: return CNT_W'(ext);
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/evcnt_ctr.sv
module evcnt_ctr
  import evcnt_pkg::*;
#(
  parameter int BASE   = 'h10,
  parameter int EV_N   = 26,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [EV_N-1:0]   ev,
  input  logic              ce,
  input  logic [QUAL_W-1:0] qual,
  input  logic [INC_W-1:0]  inc,
  output logic [31:0]       rdata,
  output logic              wrap
);

  localparam int SPAN = 'h28;

  logic [ADDR_W-1:0] rel;
  logic              hit;
  assign rel = addr - ADDR_W'(BASE);
  assign hit = (addr >= ADDR_W'(BASE)) && (rel < ADDR_W'(SPAN));

  logic sel_mlo, sel_mhi, sel_tlo, sel_thi, sel_ctl, sel_val;
  assign sel_mlo = hit && (rel == ADDR_W'('h00));
  assign sel_mhi = hit && (rel == ADDR_W'('h04));
  assign sel_tlo = hit && (rel == ADDR_W'('h08));
  assign sel_thi = hit && (rel == ADDR_W'('h0C));
  assign sel_ctl = hit && (rel == ADDR_W'('h10));
  assign sel_val = hit && (rel == ADDR_W'('h20));

  logic [QUAL_W-1:0] mask_q, match_q;
  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  val_q;

  // Named internal events
  logic              wr_val;
  logic              ev_act;
  logic              qual_ok;
  logic              cnt_fire;
  logic [CNT_W-1:0]  step;
  logic [CNT_W-1:0]  sum;
  logic              carry;

  assign wr_val = wr_en && sel_val;

  always_comb begin
    ev_act = 1'b0;
    for (int i = 0; i < EV_N; i++) begin
      if (ctrl_q.sel == 5'(i)) ev_act = ev[i];
    end
  end

  assign qual_ok  = qual_pass(qual, mask_q, match_q, ctrl_q.inv);
  assign cnt_fire = ctrl_q.en && ce && ev_act && qual_ok && (ctrl_q.mode != INC_NONE);
  assign step     = step_amount(ctrl_q.mode, inc);
  assign {carry, sum} = {1'b0, val_q} + {1'b0, step};
  assign wrap     = cnt_fire && carry && !wr_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      match_q <= '0;
      ctrl_q  <= '0;
      val_q   <= '0;
    end else begin
      if (wr_en && sel_mlo) mask_q[31:0]         <= wdata;
      if (wr_en && sel_mhi) mask_q[QUAL_W-1:32]  <= wdata[HI_W-1:0];
      if (wr_en && sel_tlo) match_q[31:0]        <= wdata;
      if (wr_en && sel_thi) match_q[QUAL_W-1:32] <= wdata[HI_W-1:0];
      if (wr_en && sel_ctl) ctrl_q               <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (wr_val)        val_q <= wdata;
      else if (cnt_fire) val_q <= sum;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) begin
      case (rel)
        ADDR_W'('h00): rdata = mask_q[31:0];
        ADDR_W'('h04): rdata = 32'(mask_q[QUAL_W-1:32]);
        ADDR_W'('h08): rdata = match_q[31:0];
        ADDR_W'('h0C): rdata = 32'(match_q[QUAL_W-1:32]);
        ADDR_W'('h10): rdata = 32'(ctrl_q);
        ADDR_W'('h20): rdata = val_q;
        default:       rdata = '0;
      endcase
    end
  end

  // R7: a value write loads the written data
  a_r7_preload: assert property (@(posedge clk) disable iff (!rst_n)
    wr_val |=> (val_q == $past(wdata)));

  // R3: a disabled counter holds its value
  a_r3_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.en && !wr_val) |=> $stable(val_q));

  // R4: group clock-enable low freezes the counter
  a_r4_ce_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce && !wr_val) |=> $stable(val_q));

  // R6: mode 3 counts nothing
  a_r6_mode3_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl_q.mode == INC_NONE) && !wr_val) |=> $stable(val_q));

  // R6: mode 0 steps by exactly one
  a_r6_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_fire && (ctrl_q.mode == INC_ONE) && !wr_val) |=> (val_q == $past(val_q) + 32'd1));

endmodule

// File: rtl/evcnt_stat.sv
module evcnt_stat #(
  parameter int N_HALF    = 8,
  parameter int N_FULL    = 2,
  parameter int ADDR_W    = 12,
  parameter int HALF_ADDR = 'h8,
  parameter int FULL_ADDR = 'hC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_HALF-1:0] wdata,
  input  logic [N_HALF-1:0] wrap_h,
  input  logic [N_FULL-1:0] wrap_f,
  output logic [31:0]       rdata,
  output logic              irq
);

  logic [N_HALF-1:0] stat_h;
  logic [N_FULL-1:0] stat_f;
  logic              wr_h, wr_f;

  assign wr_h = wr_en && (addr == ADDR_W'(HALF_ADDR));
  assign wr_f = wr_en && (addr == ADDR_W'(FULL_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_h <= '0;
      stat_f <= '0;
    end else begin
      stat_h <= (wr_h ? (stat_h & wdata) : stat_h) | wrap_h;
      stat_f <= (wr_f ? (stat_f & wdata[N_FULL-1:0]) : stat_f) | wrap_f;
    end
  end

  assign irq = (|stat_h) || (|stat_f);

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(HALF_ADDR)) rdata = 32'(stat_h);
    else if (addr == ADDR_W'(FULL_ADDR)) rdata = 32'(stat_f);
  end

  // R8: a wrap sets its status bit
  a_r8_wrap_sets_h: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap_h) |=> ((stat_h & $past(wrap_h)) == $past(wrap_h)));
  a_r8_wrap_sets_f: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap_f) |=> ((stat_f & $past(wrap_f)) == $past(wrap_f)));

  // R9: without a status write no bit ever clears
  a_r9_sticky_h: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_h |=> ((stat_h & $past(stat_h)) == $past(stat_h)));
  a_r9_sticky_f: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_f |=> ((stat_f & $past(stat_f)) == $past(stat_f)));

  // R10: a wrap raises the interrupt at the next cycle
  a_r10_irq_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ((|wrap_h) || (|wrap_f)) |=> irq);

endmodule

// File: rtl/evcnt_unit.sv
module evcnt_unit
  import evcnt_pkg::*;
#(
  parameter int N_HALF   = 8,
  parameter int N_FULL   = 2,
  parameter int EV_HALF  = 26,
  parameter int EV_FULL  = 3,
  parameter int ADDR_W   = 12,
  parameter int CTR_BASE = 'h10,
  parameter int CTR_SPAN = 'h28
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               half_ce,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  input  logic [EV_HALF-1:1] ev_half,
  input  logic [EV_FULL-1:1] ev_full,
  input  logic [QUAL_W-1:0]  qual_data,
  input  logic [INC_W-1:0]   half_inc,
  input  logic [INC_W-1:0]   full_inc,
  output logic               irq
);

  localparam int N_ALL = N_HALF + N_FULL;

  logic [31:0]       rd_ctr [N_ALL];
  logic [N_HALF-1:0] wrap_h;
  logic [N_FULL-1:0] wrap_f;
  logic [31:0]       rd_stat;
  logic [EV_HALF-1:0] ev_h_all;
  logic [EV_FULL-1:0] ev_f_all;

  // Event 0 is the group's cycle count
  assign ev_h_all = {ev_half, 1'b1};
  assign ev_f_all = {ev_full, 1'b1};

  for (genvar g = 0; g < N_HALF; g++) begin : g_half
    evcnt_ctr #(
      .BASE   (CTR_BASE + CTR_SPAN * g),
      .EV_N   (EV_HALF),
      .ADDR_W (ADDR_W)
    ) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .addr  (addr),
      .wdata (wdata),
      .ev    (ev_h_all),
      .ce    (half_ce),
      .qual  (qual_data),
      .inc   (half_inc),
      .rdata (rd_ctr[g]),
      .wrap  (wrap_h[g])
    );
  end

  for (genvar g = 0; g < N_FULL; g++) begin : g_full
    evcnt_ctr #(
      .BASE   (CTR_BASE + CTR_SPAN * (N_HALF + g)),
      .EV_N   (EV_FULL),
      .ADDR_W (ADDR_W)
    ) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .addr  (addr),
      .wdata (wdata),
      .ev    (ev_f_all),
      .ce    (1'b1),
      .qual  (qual_data),
      .inc   (full_inc),
      .rdata (rd_ctr[N_HALF + g]),
      .wrap  (wrap_f[g])
    );
  end

  evcnt_stat #(
    .N_HALF (N_HALF),
    .N_FULL (N_FULL),
    .ADDR_W (ADDR_W)
  ) u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata[N_HALF-1:0]),
    .wrap_h (wrap_h),
    .wrap_f (wrap_f),
    .rdata  (rd_stat),
    .irq    (irq)
  );

  always_comb begin
    rdata = rd_stat;
    for (int i = 0; i < N_ALL; i++) rdata = rdata | rd_ctr[i];
  end

  // R1/R10: the interrupt is low right after reset
  a_r1_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq);

endmodule

// File: tb/evcnt_unit_tb.sv
`timescale 1ns/1ps
module evcnt_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        half_ce = 1'b1;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [25:1] ev_half = '0;
  logic [2:1]  ev_full = '0;
  logic [44:0] qual_data = '0;
  logic [3:0]  half_inc = '0;
  logic [3:0]  full_inc = '0;
  logic        irq;

  always #2.5 clk = ~clk;

  evcnt_unit u_dut (
    .clk(clk), .rst_n(rst_n), .half_ce(half_ce), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ev_half(ev_half),
    .ev_full(ev_full), .qual_data(qual_data), .half_inc(half_inc),
    .full_inc(full_inc), .irq(irq)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // scoreboard queues
  logic [31:0] q_exp [$];
  bit          q_irq [$];
  string       q_tag [$];

  function automatic logic [11:0] cbase(int n);
    return 12'('h10 + 'h28 * n);
  endfunction

  // monitor: pops expected items and compares
  initial begin
    forever begin
      wait (q_exp.size() != 0);
      #1;
      begin
        logic [31:0] e, act;
        bit k;
        string t;
        e = q_exp.pop_front();
        k = q_irq.pop_front();
        t = q_tag.pop_front();
        act = k ? 32'(irq) : rdata;
        n_run++;
        if (act !== e) begin
          n_fail++;
          $display("FAIL %s: actual 0x%08h expected 0x%08h", t, act, e);
        end
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk(input logic [11:0] a, input logic [31:0] e, input string t);
    addr = a;
    q_irq.push_back(1'b0); q_tag.push_back(t); q_exp.push_back(e);
    wait (q_exp.size() == 0);
    @(negedge clk);
  endtask

  task automatic chk_irq(input bit e, input string t);
    q_irq.push_back(1'b1); q_tag.push_back(t); q_exp.push_back(32'(e));
    wait (q_exp.size() == 0);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1: reset state
    chk(cbase(0) + 12'h10, 32'h0, "R1 ctrl0");
    chk(cbase(9) + 12'h20, 32'h0, "R1 val9");
    chk(12'h008, 32'h0, "R1 stat half");
    chk(12'h00C, 32'h0, "R1 stat full");
    chk_irq(1'b0, "R1 irq");

    // R2: map and field widths
    wr(cbase(3) + 12'h04, 32'hFFFF_FFFF);
    chk(cbase(3) + 12'h04, 32'h0000_1FFF, "R2 mask hi width");
    wr(cbase(3) + 12'h04, 32'h0);
    wr(cbase(2) + 12'h10, 32'hFFFF_FFFF);
    chk(cbase(2) + 12'h10, 32'h0000_01FF, "R2 ctrl width");
    wr(cbase(2) + 12'h10, 32'h0);
    wr(cbase(1) + 12'h0C, 32'h0000_0ABC);
    chk(cbase(1) + 12'h0C, 32'h0000_0ABC, "R2 match hi");
    wr(cbase(1) + 12'h0C, 32'h0);
    chk(12'h000, 32'h0, "R2 unmapped 0x0");
    chk(cbase(0) + 12'h14, 32'h0, "R2 gap");

    // R3/R4: event 0 on counter 0, 5 counting edges
    wr(cbase(0) + 12'h10, 32'h001);
    idle(4);
    wr(cbase(0) + 12'h10, 32'h000);
    chk(cbase(0) + 12'h20, 32'd5, "R3 event0 count");
    idle(3);
    chk(cbase(0) + 12'h20, 32'd5, "R3 disabled holds");

    // R4: half_ce low freezes half group, full group still counts
    half_ce = 1'b0;
    wr(cbase(1) + 12'h10, 32'h001);
    wr(cbase(8) + 12'h10, 32'h001);
    idle(3);
    wr(cbase(1) + 12'h10, 32'h000);
    wr(cbase(8) + 12'h10, 32'h000);
    half_ce = 1'b1;
    chk(cbase(8) + 12'h20, 32'd5, "R4 full group counts");
    chk(cbase(1) + 12'h20, 32'd0, "R4 half_ce gate");
    chk(cbase(0) + 12'h20, 32'd5, "R11 neighbour untouched");

    // R4: unimplemented selects never count
    ev_full = '1; ev_half = '1;
    wr(cbase(9) + 12'h10, 32'h015);
    wr(cbase(2) + 12'h10, 32'h069);
    idle(3);
    wr(cbase(9) + 12'h10, 32'h000);
    wr(cbase(2) + 12'h10, 32'h000);
    ev_full = '0; ev_half = '0;
    chk(cbase(9) + 12'h20, 32'd0, "R4 full select 5 ignored");
    chk(cbase(2) + 12'h20, 32'd0, "R4 half select 26 ignored");

    // R5: qualifier on counter 3, event 1
    ev_half[1] = 1'b1;
    wr(cbase(3) + 12'h00, 32'h0000_00FF);
    wr(cbase(3) + 12'h08, 32'h0000_005A);
    qual_data = 45'h5A;
    wr(cbase(3) + 12'h10, 32'h005);
    idle(2);
    wr(cbase(3) + 12'h10, 32'h000);
    chk(cbase(3) + 12'h20, 32'd3, "R5 match counts");
    wr(cbase(3) + 12'h20, 32'h0);
    wr(cbase(3) + 12'h10, 32'h007);
    idle(2);
    wr(cbase(3) + 12'h10, 32'h000);
    chk(cbase(3) + 12'h20, 32'd0, "R5 inverted match blocks");
    qual_data = 45'h5B;
    wr(cbase(3) + 12'h10, 32'h007);
    idle(2);
    wr(cbase(3) + 12'h10, 32'h000);
    chk(cbase(3) + 12'h20, 32'd3, "R5 inverted mismatch counts");
    qual_data = 45'h15B;
    wr(cbase(3) + 12'h20, 32'h0);
    wr(cbase(3) + 12'h10, 32'h005);
    idle(2);
    wr(cbase(3) + 12'h10, 32'h000);
    chk(cbase(3) + 12'h20, 32'd0, "R5 low byte mismatch");
    ev_half[1] = 1'b0;

    // R6: increment modes on counter 4
    wr(cbase(4) + 12'h10, 32'h081);
    idle(1);
    wr(cbase(4) + 12'h10, 32'h000);
    chk(cbase(4) + 12'h20, 32'd4, "R6 mode1 adds 2");
    half_inc = 4'd5;
    wr(cbase(4) + 12'h20, 32'h0);
    wr(cbase(4) + 12'h10, 32'h101);
    idle(1);
    wr(cbase(4) + 12'h10, 32'h000);
    chk(cbase(4) + 12'h20, 32'd10, "R6 mode2 adds inc");
    wr(cbase(4) + 12'h20, 32'h0);
    wr(cbase(4) + 12'h10, 32'h181);
    idle(1);
    wr(cbase(4) + 12'h10, 32'h000);
    chk(cbase(4) + 12'h20, 32'd0, "R6 mode3 idle");

    // R7/R8: half-group wrap on counter 5 (bit 5 of 0x8)
    wr(cbase(5) + 12'h20, 32'hFFFF_FFFF);
    wr(cbase(5) + 12'h10, 32'h081);
    wr(cbase(5) + 12'h10, 32'h000);
    chk(cbase(5) + 12'h20, 32'd1, "R7 wrap modulo");
    chk(12'h008, 32'h20, "R8 half status bit");
    chk_irq(1'b1, "R10 irq set");
    wr(12'h008, 32'hFFFF_FFFF);
    chk(12'h008, 32'h20, "R9 write 1 keeps bit");

    // R8: full-group wrap on counter 8 (bit 0 of 0xC)
    wr(cbase(8) + 12'h20, 32'hFFFF_FFFE);
    wr(cbase(8) + 12'h10, 32'h001);
    idle(1);
    wr(cbase(8) + 12'h10, 32'h000);
    chk(cbase(8) + 12'h20, 32'd0, "R7 wrap to zero");
    chk(12'h00C, 32'h1, "R8 full status bit");
    wr(12'h00C, 32'h0);
    chk(12'h00C, 32'h0, "R9 full clear");
    chk_irq(1'b1, "R10 irq held by half");
    wr(12'h008, 32'h0);
    chk_irq(1'b0, "R10 irq cleared");

    // R7: value write wins over counting
    wr(cbase(6) + 12'h10, 32'h001);
    wr(cbase(6) + 12'h20, 32'h100);
    wr(cbase(6) + 12'h10, 32'h000);
    chk(cbase(6) + 12'h20, 32'h101, "R7 write precedence");

    // R9: wrap coinciding with status clear
    wr(cbase(7) + 12'h20, 32'hFFFF_FFFD);
    wr(cbase(7) + 12'h10, 32'h001);
    idle(2);
    wr(12'h008, 32'h0);
    wr(cbase(7) + 12'h10, 32'h000);
    chk(cbase(7) + 12'h20, 32'd1, "R7 count through wrap");
    chk(12'h008, 32'h80, "R9 wrap beats clear");
    chk_irq(1'b1, "R10 irq after coincident wrap");
    wr(12'h008, 32'h0);
    chk(12'h008, 32'h0, "R9 later clear");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule